// File: doc/BRIEF.md
# Pulse-Timed RC Successive Approximation Controller

This block runs a successive-approximation conversion where the trial voltage is not produced by a resistor-ladder DAC. Instead, a single digital output charges or discharges an external RC network. An external comparator reports whether the analog input lies above the RC voltage. For each result bit, the controller holds the drive pin at a fixed level for a number of clocks. That number is weighted by the bit position, so the first interval moves the RC node to mid-scale and each later interval is half as long as the one before. At the end of each interval the controller samples the comparator and decides the bit. The level it drives next steers the RC voltage toward the input.

Several slowly varying voltages can share one controller. Each has its own comparator, and a channel number picks which comparator takes part in a conversion. The channel is latched at the start pulse. When the conversion finishes, the result code and the channel it belongs to are published together with a one-clock completion strobe.

Top module: `rcsar_ctrl`

## Requirements
- R1: After reset the drive pin is low, busy and done are low, and the result code and result channel are zero.
- R2: A start pulse seen while idle raises busy on the next clock. From that clock, the drive pin is high for the first (most significant) interval. Whenever the block is idle, the drive pin is low.
- R3: The interval for bit k (k = 0 is the least significant bit) lasts exactly BASE_CNT·2^k clocks. Busy therefore stays high for exactly BASE_CNT·(2^RES_BITS − 1) consecutive clocks per conversion.
- R4: The comparator of the active channel passes through a two-flop synchronizer and is sampled on the last clock of each interval. A sampled 1 (input above RC voltage) makes the current bit 1, and a sampled 0 makes it 0. The finished code is these bits, with the first decided bit as the most significant bit.
- R5: In every interval after the first, the drive pin equals the bit decided in the interval before it. It is high after a 1, so the RC voltage rises, and low after a 0, so it falls.
- R6: Done is high for exactly one clock, on the clock right after the last interval. Busy is low in that clock. The result code and the result channel take their new values in that same clock.
- R7: The channel select is captured with the start pulse and used for the whole conversion. Changes on the select input, and activity on the other channels' comparators, do not affect the result.
- R8: A start pulse that arrives while busy is ignored. The running conversion keeps its length, channel and result.
- R9: The result code and result channel hold their values in every clock in which done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, accepted only while idle |
| sel_i | input | CH_W | Channel number to convert |
| cmp_i | input | NUM_CH | Comparator outputs, one per channel (1 = input above RC voltage) |
| drive_o | output | 1 | Drive pin to the RC network (1 charges, 0 discharges) |
| code_o | output | RES_BITS | Last finished conversion result |
| chan_o | output | CH_W | Channel that produced code_o |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock strobe when a new result is published |

## Verification
The bound checker enforces the conversion length on every cycle, using a counter of consecutive busy clocks. This also catches a restart from an ignored start pulse. On every cycle it also checks the single-clock done strobe, its alignment with the falling edge of busy, the low drive pin while idle, the high first interval, and the holding of the result registers between strobes. Whether the decided bits and the drive levels actually follow the comparator can only be shown by the bench. The bench closes the loop through a behavioural RC integrator with a linear charge rate, so the analog input level determines the expected code and the expected drive level at each interval boundary. The bench also stimulates the channel select and the unselected comparators during a conversion, so that their lack of effect shows in the published result.

// File: rtl/rcsar_pkg.sv
package rcsar_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

endpackage

// File: rtl/rcsar_sync.sv
module rcsar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = d_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rcsar_timer.sv
module rcsar_timer #(
    parameter int RES_BITS = 8,
    parameter int BASE_CNT = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_idx_i,
    output logic             last_o
);

    localparam int CNT_W = $clog2(BASE_CNT + 1) + RES_BITS;
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_CNT);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = BASE_V << load_idx_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rcsar_seq.sv
module rcsar_seq
    import rcsar_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int CH_W     = 2,
    parameter int IDX_W    = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [CH_W-1:0]     sel_i,
    input  logic                cmp_i,
    input  logic                last_i,
    output logic                load_o,
    output logic [IDX_W-1:0]    load_idx_o,
    output logic [CH_W-1:0]     act_ch_o,
    output logic                drive_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] code_o,
    output logic [CH_W-1:0]     chan_o
);

    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_BITS - 1);

    typedef struct packed {
        sq_state_e             state;
        logic [IDX_W-1:0]      idx;
        logic [RES_BITS-1:0]   bits;
        logic                  drv;
        logic                  done;
        logic [RES_BITS-1:0]   code;
        logic [CH_W-1:0]       ch_act;
        logic [CH_W-1:0]       ch_res;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load_o     = 1'b0;
        load_idx_o = seq_q.idx;
        case (seq_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    seq_d.state  = SQ_RUN;
                    seq_d.idx    = MSB_IDX;
                    seq_d.bits   = '0;
                    seq_d.drv    = 1'b1;
                    seq_d.ch_act = sel_i;
                    load_o       = 1'b1;
                    load_idx_o   = MSB_IDX;
                end
            end
            SQ_RUN: begin
                if (last_i) begin
                    seq_d.bits[seq_q.idx] = cmp_i;
                    if (seq_q.idx == '0) begin
                        seq_d.state  = SQ_IDLE;
                        seq_d.drv    = 1'b0;
                        seq_d.done   = 1'b1;
                        seq_d.code   = seq_d.bits;
                        seq_d.ch_res = seq_q.ch_act;
                    end else begin
                        seq_d.idx  = seq_q.idx - IDX_W'(1);
                        seq_d.drv  = cmp_i;
                        load_o     = 1'b1;
                        load_idx_o = seq_q.idx - IDX_W'(1);
                    end
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign act_ch_o = seq_q.ch_act;
    assign drive_o  = seq_q.drv;
    assign busy_o   = (seq_q.state == SQ_RUN);
    assign done_o   = seq_q.done;
    assign code_o   = seq_q.code;
    assign chan_o   = seq_q.ch_res;

endmodule

// File: rtl/rcsar_ctrl.sv
module rcsar_ctrl #(
    parameter int RES_BITS    = 8,
    parameter int NUM_CH      = 4,
    parameter int BASE_CNT    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [CH_W-1:0]     sel_i,
    input  logic [NUM_CH-1:0]   cmp_i,
    output logic                drive_o,
    output logic [RES_BITS-1:0] code_o,
    output logic [CH_W-1:0]     chan_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam int PAD_W = 2 ** CH_W;

    logic [CH_W-1:0]  act_ch;
    logic [PAD_W-1:0] cmp_pad;
    logic             cmp_mux;
    logic             cmp_sync;
    logic             last;
    logic             load;
    logic [IDX_W-1:0] load_idx;

    assign cmp_pad = PAD_W'(cmp_i);
    assign cmp_mux = cmp_pad[act_ch];

    rcsar_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (cmp_mux),
        .q_o    (cmp_sync)
    );

    rcsar_timer #(
        .RES_BITS (RES_BITS),
        .BASE_CNT (BASE_CNT),
        .IDX_W    (IDX_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_idx_i (load_idx),
        .last_o     (last)
    );

    rcsar_seq #(
        .RES_BITS (RES_BITS),
        .CH_W     (CH_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .sel_i      (sel_i),
        .cmp_i      (cmp_sync),
        .last_i     (last),
        .load_o     (load),
        .load_idx_o (load_idx),
        .act_ch_o   (act_ch),
        .drive_o    (drive_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .code_o     (code_o),
        .chan_o     (chan_o)
    );

endmodule

// File: rtl/rcsar_ctrl_chk.sv
module rcsar_ctrl_chk #(
    parameter int RES_BITS = 8,
    parameter int BASE_CNT = 8,
    parameter int CH_W     = 2
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                drive_o,
    input logic [RES_BITS-1:0] code_o,
    input logic [CH_W-1:0]     chan_o,
    input logic                busy_o,
    input logic                done_o
);

    localparam int TOTAL = BASE_CNT * ((2 ** RES_BITS) - 1);

    int busy_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_run_q <= 0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + 1;
        end else begin
            busy_run_q <= 0;
        end
    end

    p_idle_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !drive_o);

    p_start_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && drive_o));

    p_first_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> drive_o);

    p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (busy_run_q == TOTAL));

    p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (busy_run_q < TOTAL));

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(code_o) && $stable(chan_o)));

endmodule

bind rcsar_ctrl rcsar_ctrl_chk #(
    .RES_BITS (RES_BITS),
    .BASE_CNT (BASE_CNT),
    .CH_W     (CH_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .drive_o (drive_o),
    .code_o  (code_o),
    .chan_o  (chan_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/rcsar_ctrl_bench.sv
module rcsar_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RES_BITS   = 8;
    localparam int NUM_CH     = 4;
    localparam int BASE_CNT   = 8;
    localparam int CH_W       = 2;
    localparam int TOTAL      = BASE_CNT * ((2 ** RES_BITS) - 1);
    localparam int WD_LIMIT   = 190000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [CH_W-1:0]     sel = '0;
    logic [NUM_CH-1:0]   cmp = '0;
    logic                drive;
    logic [RES_BITS-1:0] code;
    logic [CH_W-1:0]     chan;
    logic                busy;
    logic                done;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int rc_v     = 0;
    int ana_lvl  = 0;
    int cur_ch   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rcsar_ctrl #(
        .RES_BITS (RES_BITS),
        .NUM_CH   (NUM_CH),
        .BASE_CNT (BASE_CNT),
        .CH_W     (CH_W)
    ) u_rcsar_ctrl (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .sel_i   (sel),
        .cmp_i   (cmp),
        .drive_o (drive),
        .code_o  (code),
        .chan_o  (chan),
        .busy_o  (busy),
        .done_o  (done)
    );

    // Behavioural RC node: one unit per clock up or down, discharged when a conversion is accepted.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (start && !busy) begin
            rc_v = 0;
        end else if (drive) begin
            rc_v = rc_v + 1;
        end else if (rc_v > 0) begin
            rc_v = rc_v - 1;
        end
        if (cyc == WD_LIMIT) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Selected comparator follows the model; all other comparators show the opposite answer.
    always @(negedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            cmp[c] = (c == cur_ch) ? (ana_lvl > rc_v) : !(ana_lvl > rc_v);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_code(input int lvl);
        int v;
        int d;
        int res;
        v   = 0;
        d   = 1;
        res = 0;
        for (int k = RES_BITS - 1; k >= 0; k--) begin
            v = d ? v + (BASE_CNT << k) : v - (BASE_CNT << k);
            d = (lvl > v) ? 1 : 0;
            res = res | (d << k);
        end
        return res;
    endfunction

    task automatic run_conv(input int m, input int ch, input bit poke);
        int exp_code;
        int n;
        int s;
        int starts[RES_BITS];
        int lvls[RES_BITS];
        int prev_code;
        int prev_chan;
        bit seen;
        ana_lvl  = BASE_CNT * m + BASE_CNT / 2;
        exp_code = expect_code(ana_lvl);
        s = 1;
        for (int k = RES_BITS - 1; k >= 0; k--) begin
            starts[k] = s;
            lvls[k]   = (k == RES_BITS - 1) ? 1 : ((exp_code >> (k + 1)) & 1);
            s = s + (BASE_CNT << k);
        end
        @(negedge clk);
        cur_ch = ch;
        sel    = CH_W'(ch);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        sel    = CH_W'(ch + 1);
        n      = 1;
        seen   = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (n <= TOTAL + 4) begin
            for (int k = 0; k < RES_BITS; k++) begin
                if (n == starts[k]) begin
                    check(drive == lvls[k][0], (k == RES_BITS - 1) ? "R2" : "R5",
                          "drive at interval start", int'(drive), lvls[k]);
                end
            end
            if (poke && n == 300) begin
                start = 1'b1;
                sel   = CH_W'(ch + 2);
            end
            if (poke && n == 301) begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            n = n + 1;
        end
        check(seen, "R6", "done seen", int'(seen), 1);
        check(n == TOTAL + 1, "R3", "done cycle after start", n, TOTAL + 1);
        check(busy == 1'b0, "R6", "busy low with done", int'(busy), 0);
        check(int'(code) == exp_code, poke ? "R8" : "R4", "result code", int'(code), exp_code);
        check(int'(chan) == ch, "R7", "result channel", int'(chan), ch);
        prev_code = int'(code);
        prev_chan = int'(chan);
        @(negedge clk);
        check(done == 1'b0, "R6", "done single clock", int'(done), 0);
        sel = CH_W'(ch + 3);
        ana_lvl = BASE_CNT * 300;
        repeat (3) @(negedge clk);
        check(int'(code) == prev_code && int'(chan) == prev_chan, "R9",
              "result held while idle", int'(code), prev_code);
        check(drive == 1'b0, "R2", "drive low when idle", int'(drive), 0);
    endtask

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        check(drive == 1'b0, "R1", "drive in reset", int'(drive), 0);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'(busy), 0);
        check(code == '0 && chan == '0, "R1", "result in reset", int'(code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(code == '0 && drive == 1'b0, "R1", "state after release", int'(code), 0);

        run_conv(0, 0, 1'b0);
        run_conv(255, 3, 1'b0);
        run_conv(127, 1, 1'b0);
        run_conv(128, 2, 1'b1);
        run_conv(85, 1, 1'b1);
        run_conv(170, 3, 1'b0);
        for (int i = 0; i < 26; i++) begin
            run_conv(int'($urandom_range(255, 0)), int'($urandom_range(NUM_CH - 1, 0)),
                     1'($urandom_range(1, 0)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule